// File: doc/BRIEF.md
# Programmable UART Baud Rate Generator

This block derives the bit timing of a serial port from the system clock. A 12-bit divisor, loaded through two byte-wide register writes, sets the reload value of a down-counter. Every time that counter reaches zero the block emits a one-cycle tick. The receiver uses this tick directly as its oversampling strobe. A post-divider then turns the tick into a transmit bit-clock enable. Its ratio depends on the operating mode.

Three control inputs select the mode: a synchronous/asynchronous select, a double-speed bit, and the direction of the external clock pin. The resulting mode is asynchronous normal, asynchronous double speed, synchronous master, or synchronous slave. In synchronous master mode the block also drives a clock level for the external clock pin. In slave mode the block leaves transmit timing to an external clock. It then holds its transmit enable and clock level low.

All outputs are registered. They change one clock after the condition that causes them.

Top module: `uart_rate_gen`

## Requirements
- R1: With divisor D (D > 0) held and no low-byte write, `rx_tick` is a one-cycle pulse that recurs exactly every D+1 clock cycles.
- R2: With divisor 0, `rx_tick` is high on every cycle that does not follow a low-byte write.
- R3: A low-byte write reloads the counter at once. `rx_tick` is low in the cycle after the write, and the first tick appears D+1 cycles after the write is sampled.
- R4: A high-byte write only stores `wr_data[3:0]` in a holding register. The divisor and the tick rhythm are unchanged until a low-byte write, which loads the divisor as {held nibble, `wr_data[7:0]`}. When both writes happen in the same cycle, the low-byte write uses the previously held nibble.
- R5: In asynchronous normal mode (`sync_sel`=0, `dbl_speed`=0), `tx_bit_en` pulses together with every 16th tick.
- R6: In asynchronous double-speed mode (`sync_sel`=0, `dbl_speed`=1), `tx_bit_en` pulses together with every 8th tick.
- R7: In synchronous master mode (`sync_sel`=1, `clk_pin_out`=1, with `dbl_speed` ignored), `tx_bit_en` pulses with every 2nd tick and `sync_clk` toggles on every tick.
- R8: In synchronous slave mode (`sync_sel`=1, `clk_pin_out`=0), `tx_bit_en` and `sync_clk` stay low while `rx_tick` keeps running. Outside master mode, `sync_clk` is low.
- R9: The post-divider count clears on a low-byte write and on any change of the decoded mode. A tick in a mode-change cycle is not counted, so the first transmit enable after either event comes after a full ratio of ticks.
- R10: A synchronous active-high `rst` clears the counter, the held nibble, the divisor and the post-divider. It holds all outputs low, and asynchronous normal mode is taken as the previous mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_hi | input | 1 | Write strobe for the divisor's upper nibble (holding register) |
| wr_lo | input | 1 | Write strobe for the divisor's low byte; commits divisor and reloads |
| wr_data | input | 8 | Write data byte |
| sync_sel | input | 1 | 1 = synchronous operation, 0 = asynchronous |
| dbl_speed | input | 1 | Double-speed select for asynchronous operation |
| clk_pin_out | input | 1 | External clock pin direction, 1 = driven by this block (master) |
| rx_tick | output | 1 | Raw divided tick for receiver oversampling |
| tx_bit_en | output | 1 | One-cycle transmit bit-clock enable |
| sync_clk | output | 1 | Synchronous master clock level for the external pin |

## Verification
The bench targets several timing corner cases, each of which a faulty design would get wrong in a visible way. Divisor zero must tick on every cycle; an off-by-one counter would drop to half rate or stall. A high-byte write on its own must leave the tick rhythm alone; a design that commits it at once would shift the period early. Low-byte writes arrive in the middle of a count, where a design that waits for the old count to expire would place the next tick late. Mode changes and reloads arrive in the middle of a bit, where a post-divider that is not cleared would issue a short first transmit bit. Slave mode checks that the transmit enable and pin clock stay silent.

// File: rtl/uart_rate_pkg.sv
package uart_rate_pkg;

  typedef enum logic [1:0] {
    MODE_ASYNC_NORM  = 2'd0,
    MODE_ASYNC_DBL   = 2'd1,
    MODE_SYNC_MASTER = 2'd2,
    MODE_SYNC_SLAVE  = 2'd3
  } rate_mode_e;

  // Mode decode: the pin direction only matters for synchronous operation,
  // and double speed only matters for asynchronous operation.
  function automatic rate_mode_e decode_mode(input logic sync_sel,
                                             input logic dbl_speed,
                                             input logic pin_out);
    rate_mode_e m;
    if (!sync_sel)     m = dbl_speed ? MODE_ASYNC_DBL : MODE_ASYNC_NORM;
    else if (pin_out)  m = MODE_SYNC_MASTER;
    else               m = MODE_SYNC_SLAVE;
    return m;
  endfunction

endpackage

// File: rtl/rate_div_regs.sv
module rate_div_regs #(
  parameter int DIV_W  = 12,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_hi,
  input  logic              wr_lo,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [DIV_W-1:0]  load_val,
  output logic [DIV_W-1:0]  div_q
);
  localparam int HI_W = DIV_W - BYTE_W;

  generate
    if (HI_W > 0) begin : g_hold
      logic [HI_W-1:0] hold_q;
      always_ff @(posedge clk) begin
        if (rst)        hold_q <= '0;
        else if (wr_hi) hold_q <= wr_data[HI_W-1:0];
      end
      assign load_val = {hold_q, wr_data};
    end else begin : g_nohold
      assign load_val = wr_data[DIV_W-1:0];
    end
  endgenerate

  // R4: divisor commits only on the low-byte write
  always_ff @(posedge clk) begin
    if (rst)        div_q <= '0;
    else if (wr_lo) div_q <= load_val;
  end
endmodule

// File: rtl/rate_down_counter.sv
module rate_down_counter #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [DIV_W-1:0] load_val,
  input  logic [DIV_W-1:0] div_q,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  // R3: a forced load suppresses the tick of that cycle
  assign tick = !load && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q == '0)   cnt_q <= div_q;
    else                    cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/rate_post_div.sv
module rate_post_div
  import uart_rate_pkg::*;
#(
  parameter int PD_W       = 4,
  parameter int NORM_RATIO = 16,
  parameter int DBL_RATIO  = 8,
  parameter int SYNC_RATIO = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       reload,
  input  rate_mode_e mode,
  output logic       rx_tick,
  output logic       tx_bit_en,
  output logic       sync_clk
);
  localparam logic [PD_W-1:0] NORM_LAST = PD_W'(NORM_RATIO - 1);
  localparam logic [PD_W-1:0] DBL_LAST  = PD_W'(DBL_RATIO - 1);
  localparam logic [PD_W-1:0] SYNC_LAST = PD_W'(SYNC_RATIO - 1);

  rate_mode_e      mode_q;
  logic [PD_W-1:0] pcnt_q;
  logic [PD_W-1:0] last_c;
  logic            changed_c;
  logic            quiet_c;

  always_comb begin
    case (mode)
      MODE_ASYNC_NORM:  last_c = NORM_LAST;
      MODE_ASYNC_DBL:   last_c = DBL_LAST;
      MODE_SYNC_MASTER: last_c = SYNC_LAST;
      default:          last_c = '0;
    endcase
  end

  assign changed_c = (mode != mode_q);
  assign quiet_c   = (mode == MODE_SYNC_SLAVE);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= MODE_ASYNC_NORM;
      pcnt_q    <= '0;
      rx_tick   <= 1'b0;
      tx_bit_en <= 1'b0;
      sync_clk  <= 1'b0;
    end else begin
      mode_q  <= mode;
      rx_tick <= tick;
      // R9: restart the bit period on reload or mode change
      if (changed_c || reload || quiet_c) begin
        pcnt_q    <= '0;
        tx_bit_en <= 1'b0;
      end else if (tick) begin
        if (pcnt_q == last_c) begin
          pcnt_q    <= '0;
          tx_bit_en <= 1'b1;
        end else begin
          pcnt_q    <= pcnt_q + 1'b1;
          tx_bit_en <= 1'b0;
        end
      end else begin
        tx_bit_en <= 1'b0;
      end
      // R7/R8: pin clock only runs in master mode
      if (mode == MODE_SYNC_MASTER) begin
        if (tick) sync_clk <= !sync_clk;
      end else begin
        sync_clk <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/uart_rate_gen.sv
module uart_rate_gen
  import uart_rate_pkg::*;
#(
  parameter int DIV_W      = 12,
  parameter int BYTE_W     = 8,
  parameter int PD_W       = 4,
  parameter int NORM_RATIO = 16,
  parameter int DBL_RATIO  = 8,
  parameter int SYNC_RATIO = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_hi,
  input  logic              wr_lo,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              sync_sel,
  input  logic              dbl_speed,
  input  logic              clk_pin_out,
  output logic              rx_tick,
  output logic              tx_bit_en,
  output logic              sync_clk
);
  logic [DIV_W-1:0] load_val;
  logic [DIV_W-1:0] div_q;
  logic             tick_w;
  rate_mode_e       mode_w;

  assign mode_w = decode_mode(sync_sel, dbl_speed, clk_pin_out);

  rate_div_regs #(.DIV_W(DIV_W), .BYTE_W(BYTE_W)) regs_i (
    .clk(clk), .rst(rst), .wr_hi(wr_hi), .wr_lo(wr_lo), .wr_data(wr_data),
    .load_val(load_val), .div_q(div_q)
  );

  rate_down_counter #(.DIV_W(DIV_W)) cnt_i (
    .clk(clk), .rst(rst), .load(wr_lo), .load_val(load_val),
    .div_q(div_q), .tick(tick_w)
  );

  rate_post_div #(
    .PD_W(PD_W), .NORM_RATIO(NORM_RATIO),
    .DBL_RATIO(DBL_RATIO), .SYNC_RATIO(SYNC_RATIO)
  ) pdiv_i (
    .clk(clk), .rst(rst), .tick(tick_w), .reload(wr_lo), .mode(mode_w),
    .rx_tick(rx_tick), .tx_bit_en(tx_bit_en), .sync_clk(sync_clk)
  );
endmodule

// File: rtl/uart_rate_gen_chk.sv
module uart_rate_gen_chk #(
  parameter int DIV_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_lo,
  input logic             sync_sel,
  input logic             clk_pin_out,
  input logic [DIV_W-1:0] div_q,
  input logic             rx_tick,
  input logic             tx_bit_en,
  input logic             sync_clk
);
  a_r1_tick_gap: assert property (@(posedge clk) disable iff (rst)
    (rx_tick && div_q != '0) |=> !rx_tick);

  a_r2_zero_div: assert property (@(posedge clk) disable iff (rst)
    (div_q == '0 && !wr_lo) |=> rx_tick);

  a_r3_reload_no_tick: assert property (@(posedge clk) disable iff (rst)
    wr_lo |=> !rx_tick);

  a_r5_en_with_tick: assert property (@(posedge clk) disable iff (rst)
    tx_bit_en |-> rx_tick);

  a_r7_sclk_on_tick: assert property (@(posedge clk) disable iff (rst)
    ($past(sync_sel && clk_pin_out) && (sync_clk != $past(sync_clk))) |-> rx_tick);

  a_r8_slave_quiet: assert property (@(posedge clk) disable iff (rst)
    (sync_sel && !clk_pin_out) |=> (!tx_bit_en && !sync_clk));

  a_r10_reset_clear: assert property (@(posedge clk)
    rst |=> (!rx_tick && !tx_bit_en && !sync_clk));
endmodule

bind uart_rate_gen uart_rate_gen_chk #(.DIV_W(DIV_W)) chk_i (
  .clk(clk), .rst(rst), .wr_lo(wr_lo), .sync_sel(sync_sel),
  .clk_pin_out(clk_pin_out), .div_q(div_q), .rx_tick(rx_tick),
  .tx_bit_en(tx_bit_en), .sync_clk(sync_clk)
);

// File: tb/uart_rate_gen_tb_top.sv
module uart_rate_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_hi = 1'b0;
  logic       wr_lo = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       sync_sel = 1'b0;
  logic       dbl_speed = 1'b0;
  logic       clk_pin_out = 1'b0;
  logic       rx_tick, tx_bit_en, sync_clk;

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done  = 1'b0;
  string phase = "R10";

  // reference model state
  int m_cnt = 0, m_div = 0, m_hold = 0, m_pc = 0, m_prev = 0;
  bit e_tick = 0, e_en = 0, e_sclk = 0;

  always #5 clk = ~clk;

  uart_rate_gen dut_i (
    .clk(clk), .rst(rst), .wr_hi(wr_hi), .wr_lo(wr_lo), .wr_data(wr_data),
    .sync_sel(sync_sel), .dbl_speed(dbl_speed), .clk_pin_out(clk_pin_out),
    .rx_tick(rx_tick), .tx_bit_en(tx_bit_en), .sync_clk(sync_clk)
  );

  // Behavioural model: 0 normal, 1 double, 2 master, 3 slave
  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_div = 0; m_hold = 0; m_pc = 0; m_prev = 0;
      e_tick = 0; e_en = 0; e_sclk = 0;
    end else begin
      int md, ratio;
      bit tk;
      md = !sync_sel ? (dbl_speed ? 1 : 0) : (clk_pin_out ? 2 : 3);
      ratio = (md == 0) ? 16 : (md == 1) ? 8 : 2;
      tk = !wr_lo && (m_cnt == 0);
      if (wr_lo) begin
        m_div = m_hold * 256 + wr_data;
        m_cnt = m_div;
      end else if (m_cnt == 0) m_cnt = m_div;
      else m_cnt = m_cnt - 1;
      if (wr_hi) m_hold = wr_data % 16;
      if (md != m_prev || wr_lo || md == 3) begin
        m_pc = 0; e_en = 0;
      end else if (tk) begin
        m_pc = m_pc + 1;
        e_en = (m_pc == ratio);
        if (e_en) m_pc = 0;
      end else e_en = 0;
      if (md == 2) begin
        if (tk) e_sclk = !e_sclk;
      end else e_sclk = 0;
      e_tick = tk;
      m_prev = md;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      n_cmp++;
      if (rx_tick !== e_tick || tx_bit_en !== e_en || sync_clk !== e_sclk) begin
        n_bad++;
        $display("FAIL %s t=%0t tick/en/sclk got %b%b%b exp %b%b%b",
                 phase, $time, rx_tick, tx_bit_en, sync_clk, e_tick, e_en, e_sclk);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_high(input logic [7:0] d);
    @(negedge clk); wr_hi = 1'b1; wr_data = d;
    @(negedge clk); wr_hi = 1'b0;
  endtask

  task automatic wr_low(input logic [7:0] d);
    @(negedge clk); wr_lo = 1'b1; wr_data = d;
    @(negedge clk); wr_lo = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog expired in phase %s", phase);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R10: outputs low under reset
    idle(4);
    @(negedge clk); rst = 1'b0;
    // R2: default divisor zero ticks every cycle, normal mode en every 16th
    phase = "R2"; idle(40);
    // R4: high byte alone must not change rhythm
    phase = "R4"; wr_high(8'h01); idle(20);
    wr_high(8'h00); wr_low(8'h03);
    // R1 / R5: divisor 3, normal mode
    phase = "R5"; idle(200);
    // R3: mid-count reload with a new low byte
    phase = "R3"; idle(2); wr_low(8'h05); idle(30); wr_low(8'h02); idle(1); wr_low(8'h04); idle(90);
    // R4: high nibble commits on low write; R1 period 257
    phase = "R4"; wr_high(8'hF1); idle(5); wr_low(8'h00); idle(600);
    // R4: simultaneous high and low write uses old nibble
    @(negedge clk); wr_hi = 1'b1; wr_lo = 1'b1; wr_data = 8'h03;
    @(negedge clk); wr_hi = 1'b0; wr_lo = 1'b0; idle(400);
    wr_high(8'h00); wr_low(8'h03);
    // R6: double speed
    phase = "R6"; dbl_speed = 1'b1; idle(200);
    // R7: synchronous master, dbl ignored
    phase = "R7"; sync_sel = 1'b1; clk_pin_out = 1'b1; idle(60);
    wr_low(8'h02); dbl_speed = 1'b0; idle(60);
    // R8: synchronous slave
    phase = "R8"; clk_pin_out = 1'b0; idle(60);
    // R9: mode changes and reloads mid-bit
    phase = "R9"; sync_sel = 1'b0; idle(37); dbl_speed = 1'b1; idle(13);
    wr_low(8'h01); idle(9); dbl_speed = 1'b0; idle(50);
    sync_sel = 1'b1; clk_pin_out = 1'b1; idle(7); sync_sel = 1'b0; idle(5);
    sync_sel = 1'b1; idle(30); wr_low(8'h00); idle(20);
    // R10: reset in the middle of operation
    phase = "R10"; @(negedge clk); rst = 1'b1; idle(3);
    @(negedge clk); rst = 1'b0; sync_sel = 1'b0; clk_pin_out = 1'b0;
    dbl_speed = 1'b0; idle(40);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule